// File: doc/BRIEF.md
# Nibble Calibration Pattern Generator

This block feeds a 4-bit serial trace lane with a known, repeating sequence so that the receiving side can be calibrated, tuned or tested. It produces output only while the interface is enabled and test mode is selected at the same time. It then keeps producing its sequence until either condition is removed.

A 3-bit code picks one of five sequences: two alternating pairs, a walking-ones run, a counting ramp, and a maximal-length pseudo-random sequence. The sequence moves on by one element only in a cycle where the consumer raises its ready strobe. A rise of the run condition, or a new pattern code, starts the chosen sequence again from its first element.

Top module: `nibble_pattern_gen`

## Requirements
- R1: While `rstN` is low, `nibbleValid` is 0 and `nibble` is 0x0.
- R2: "Run" means `enable` and `testMode` are both high. The outputs change one clock after each edge. After an edge where run is low, `nibbleValid` is 0 and `nibble` is 0x0. After an edge where run is high, `nibbleValid` is 1.
- R3: Code 0 gives the sequence 0x5, 0xA, 0x5, 0xA, and so on.
- R4: Code 1 gives the sequence 0x0, 0xF, 0x0, 0xF, and so on.
- R5: Code 2 gives the repeating sequence 0x0, 0x1, 0x2, 0x4, 0x8.
- R6: Code 3 gives the sequence 0x0, 0x1, and so on up to 0xF, then wraps back to 0x0.
- R7: Code 4 gives an LFSR sequence. It starts at 0x1, and each next value is {q[2:0], q[3]^q[2]} (polynomial x^4+x^3+1). It has period 15 and never shows 0x0.
- R8: Codes 5, 6 and 7 give `nibble` = 0x0 with `nibbleValid` = 1.
- R9: A restart happens at an edge where run is high and either the previous edge had run low or `patSel` differs from the code in use. After a restart, the output is the first element of the newly selected sequence.
- R10: Between two running edges with an unchanged code, the sequence advances by exactly one element if `outReady` is 1 at the edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| enable | input | 1 | Interface enable |
| testMode | input | 1 | Selects test pattern output |
| patSel | input | 3 | Pattern code |
| outReady | input | 1 | Consumer accepted the current nibble; advance |
| nibble | output | 4 | Current pattern value |
| nibbleValid | output | 1 | Generator is running |

## Verification
The properties assume that `patSel` and `outReady` are sampled only at clock edges, and that an unchanged code between two running edges means no restart has happened. The hold and pattern-membership checks are therefore conditioned on the code seen at the previous edge. Some checks refer back to earlier cycles; they look only at cycles after reset has been released. The random stimulus changes the code rarely and drops enable or test mode now and then, so that long runs of advances alternate with restarts. All of its inputs are driven at falling edges, so every edge sees stable values.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  localparam int SEL_W   = 3;
  localparam int NUM_PAT = 5;

  typedef enum logic [SEL_W-1:0] {
    PAT_ALT_A = 3'd0,
    PAT_ALT_F = 3'd1,
    PAT_WALK  = 3'd2,
    PAT_RAMP  = 3'd3,
    PAT_LFSR  = 3'd4
  } patCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             restart;
    logic             advance;
    logic             active;
    logic [SEL_W-1:0] sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             testMode,
  input  logic [SEL_W-1:0] patSel,
  input  logic             outReady,
  output ctrlStrobe_t      strobe
);

  logic             run;
  logic             activeQ;
  logic [SEL_W-1:0] selQ;
  logic             selChanged;
  logic             restartNow;

  assign run        = enable & testMode;
  assign selChanged = (patSel != selQ);
  assign restartNow = run & (~activeQ | selChanged);

  always_comb begin
    strobe.restart = restartNow;
    strobe.advance = run & activeQ & ~selChanged & outReady;
    strobe.active  = activeQ;
    strobe.sel     = selQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      selQ    <= '0;
    end else begin
      activeQ <= run;
      if (restartNow) selQ <= patSel;
    end
  end

endmodule

// File: rtl/patgen_datapath.sv
module patgen_datapath
  import patgen_pkg::*;
#(
  parameter int         W     = 4,
  parameter logic [W-1:0] SEED = 1,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic [W-1:0] nibble,
  output logic        nibbleValid
);

  localparam logic [W-1:0] ALT_A_EVEN = {(W/2){2'b01}};
  localparam logic [W-1:0] ALT_A_ODD  = ~ALT_A_EVEN;
  localparam logic [W-1:0] ONES       = '1;
  localparam logic [W-1:0] WALK_LAST  = W[W-1:0];

  logic [W-1:0] step;
  logic [W-1:0] stepNext;
  logic [W-1:0] lastStep;
  logic [W-1:0] lfsr;
  logic [W-1:0] lfsrNext;
  logic [W-1:0] patVal [NUM_PAT];
  logic [W-1:0] selVal;

  // wrap point of the step counter per pattern
  always_comb begin
    case (strobe.sel)
      PAT_ALT_A, PAT_ALT_F: lastStep = {{(W-1){1'b0}}, 1'b1};
      PAT_WALK:             lastStep = WALK_LAST;
      PAT_RAMP:             lastStep = ONES;
      default:              lastStep = '0;
    endcase
  end

  assign stepNext = (step == lastStep) ? '0 : step + 1'b1;
  assign lfsrNext = {lfsr[W-2:0], ^(lfsr & TAPS)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
      lfsr <= SEED;
    end else if (strobe.restart) begin
      step <= '0;
      lfsr <= SEED;
    end else if (strobe.advance) begin
      step <= stepNext;
      lfsr <= lfsrNext;
    end
  end

  // one candidate value per pattern
  generate
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      if (p == int'(PAT_ALT_A)) begin : g_alt_a
        assign patVal[p] = step[0] ? ALT_A_ODD : ALT_A_EVEN;
      end else if (p == int'(PAT_ALT_F)) begin : g_alt_f
        assign patVal[p] = step[0] ? ONES : '0;
      end else if (p == int'(PAT_WALK)) begin : g_walk
        assign patVal[p] = (step == '0) ? '0 : ({{(W-1){1'b0}}, 1'b1} << (step - 1'b1));
      end else if (p == int'(PAT_RAMP)) begin : g_ramp
        assign patVal[p] = step;
      end else begin : g_lfsr
        assign patVal[p] = lfsr;
      end
    end
  endgenerate

  always_comb begin
    selVal = '0;
    for (int p = 0; p < NUM_PAT; p++) begin
      if (strobe.sel == SEL_W'(p)) selVal = patVal[p];
    end
  end

  assign nibble      = strobe.active ? selVal : '0;
  assign nibbleValid = strobe.active;

endmodule

// File: rtl/nibble_pattern_gen.sv
module nibble_pattern_gen
  import patgen_pkg::*;
#(
  parameter int         W    = 4,
  parameter logic [W-1:0] SEED = 1,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             testMode,
  input  logic [SEL_W-1:0] patSel,
  input  logic             outReady,
  output logic [W-1:0]     nibble,
  output logic             nibbleValid
);

  ctrlStrobe_t strobe;

  patgen_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .testMode (testMode),
    .patSel   (patSel),
    .outReady (outReady),
    .strobe   (strobe)
  );

  patgen_datapath #(.W(W), .SEED(SEED), .TAPS(TAPS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .nibble      (nibble),
    .nibbleValid (nibbleValid)
  );

endmodule

// File: rtl/patgen_checker.sv
module patgen_checker
  import patgen_pkg::*;
#(
  parameter int W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             testMode,
  input logic [SEL_W-1:0] patSel,
  input logic             outReady,
  input logic [W-1:0]     nibble,
  input logic             nibbleValid
);

  localparam logic [W-1:0] ALT_A_FIRST = {(W/2){2'b01}};

  logic pastOk;
  logic run;
  assign run = enable & testMode;

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!nibbleValid && nibble == '0));

  p_run_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    run |=> nibbleValid);

  p_first_alt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (run && !nibbleValid && patSel == PAT_ALT_A) |=> (nibble == ALT_A_FIRST));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && nibbleValid && run && !outReady && patSel == $past(patSel))
      |=> ($stable(nibble) && nibbleValid));

  p_alt_f_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(run) && $past(patSel) == PAT_ALT_F)
      |-> (nibble == '0 || nibble == '1));

  p_walk_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(run) && $past(patSel) == PAT_WALK) |-> $onehot0(nibble));

  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(run) && $past(patSel) == PAT_LFSR) |-> (nibble != '0));

  p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(run) && $past(patSel) >= SEL_W'(NUM_PAT))
      |-> (nibble == '0 && nibbleValid));

endmodule

bind nibble_pattern_gen patgen_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .testMode    (testMode),
  .patSel      (patSel),
  .outReady    (outReady),
  .nibble      (nibble),
  .nibbleValid (nibbleValid)
);

// File: tb/nibble_pattern_gen_tb.sv
module nibble_pattern_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       testMode = 1'b0;
  logic [2:0] patSel = 3'd0;
  logic       outReady = 1'b0;
  logic [3:0] nibble;
  logic       nibbleValid;

  int checks = 0;
  int failures = 0;

  // reference state
  bit         mActive = 1'b0;
  logic [2:0] mSel = 3'd0;
  int         mK = 0;
  string      mTag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_pattern_gen u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .testMode    (testMode),
    .patSel      (patSel),
    .outReady    (outReady),
    .nibble      (nibble),
    .nibbleValid (nibbleValid)
  );

  // element k of the sequence for a code, from the requirements
  function automatic logic [3:0] seqVal(logic [2:0] sel, int k);
    logic [3:0] q;
    case (sel)
      3'd0: return (k % 2 == 0) ? 4'h5 : 4'hA;
      3'd1: return (k % 2 == 0) ? 4'h0 : 4'hF;
      3'd2: return (k % 5 == 0) ? 4'h0 : (4'h1 << ((k % 5) - 1));
      3'd3: return 4'(k % 16);
      3'd4: begin
        q = 4'h1;
        for (int i = 0; i < k % 15; i++) q = {q[2:0], q[3] ^ q[2]};
        return q;
      end
      default: return 4'h0;
    endcase
  endfunction

  function automatic string patTag(logic [2:0] sel);
    case (sel)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] expN, logic expV);
    checks++;
    if (nibble !== expN || nibbleValid !== expV) begin
      failures++;
      $display("FAIL %s: nibble=%h valid=%b expected nibble=%h valid=%b",
               tag, nibble, nibbleValid, expN, expV);
    end
  endtask

  // drive at falling edge, update reference at rising edge, compare at next falling edge
  task automatic cycle(bit en, bit tm, logic [2:0] sel, bit rdy);
    bit run;
    enable   = en;
    testMode = tm;
    patSel   = sel;
    outReady = rdy;
    @(posedge clk);
    run = en && tm;
    if (!run) begin
      mActive = 1'b0;
      mTag    = "R2";
    end else if (!mActive || sel != mSel) begin
      mActive = 1'b1;
      mSel    = sel;
      mK      = 0;
      mTag    = "R9";
    end else if (rdy) begin
      mK++;
      mTag = patTag(mSel);
    end else begin
      mTag = "R10";
    end
    @(negedge clk);
    if (!mActive) check(mTag, 4'h0, 1'b0);
    else          check(mTag, seqVal(mSel, mK), 1'b1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog R2: actual=timeout expected=finished stream");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int seedDummy;
    logic [2:0] rSel;
    seedDummy = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    check("R1", 4'h0, 1'b0);
    rstN = 1'b1;

    // enable without test mode, and test mode without enable: R2
    cycle(1, 0, 3'd0, 1);
    cycle(0, 1, 3'd0, 1);

    // each code, free running: R3..R8, first element R9
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 20; n++) cycle(1, 1, 3'(s), 1);
      cycle(0, 0, 3'(s), 1);
    end

    // hold with ready low, mid-sequence: R10
    for (int n = 0; n < 5; n++) cycle(1, 1, 3'd3, 1);
    for (int n = 0; n < 3; n++) cycle(1, 1, 3'd3, 0);
    cycle(1, 1, 3'd3, 1);

    // code change while running restarts: R9
    cycle(1, 1, 3'd4, 1);
    cycle(1, 1, 3'd4, 1);
    cycle(1, 1, 3'd2, 0);
    cycle(1, 1, 3'd2, 1);

    // test mode drop and return restarts: R2, R9
    cycle(1, 0, 3'd2, 1);
    cycle(1, 1, 3'd2, 1);

    // LFSR over more than one period: R7
    for (int n = 0; n < 40; n++) cycle(1, 1, 3'd4, 1);

    // random phase
    rSel = 3'd0;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 16 == 0) rSel = 3'($urandom % 8);
      cycle(($urandom % 10) != 0, ($urandom % 20) != 0, rSel, ($urandom % 10) < 7);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule